// File: doc/BRIEF.md
# NAND Flash Host Bridge

This block lets a processor drive a raw 8-bit NAND flash device through two 32-bit host registers. The control port takes a packed word that holds a chip-enable flag, a three-bit operation code and one byte. A control write with a command, address or data-write code produces exactly one flash bus cycle: the byte goes out under CLE, under ALE, or as plain data, and the chip-enable flag stays in force until a later control write changes it. Multi-byte transfers are built by software from repeated single-byte writes.

Reading works in a sticky mode. A control write with the read code arms the bridge without touching the flash bus. While it is armed, each host read of the data port starts one RE# pulse and returns the sampled byte. Reading the control port returns the flash ready/busy state. The WE# and RE# pulses are shaped by three parameters (setup, low pulse and hold, counted in clock cycles). A ready output holds the host off until the flash cycle in progress has finished.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset CE# is high, CLE and ALE are low, WE# and RE# are high, the flash data enable is low, read mode is off and hostReady is high.
- R2: A control-port write decodes bit 31 as chip enable, bits 30:28 as operation code and bits 23:16 as the byte; code 0 runs one write cycle with CLE high and ALE low for the whole cycle and that byte on the bus.
- R3: Code 1 runs one write cycle with ALE high and CLE low for the whole cycle, driving the byte.
- R4: Code 3 runs one write cycle with CLE and ALE both low, driving the byte.
- R5: A write cycle drives the bus for SETUP_CYC cycles with WE# high, then PULSE_CYC cycles with WE# low, then HOLD_CYC cycles with WE# high; RE# stays high, and afterwards the bus is released and CLE/ALE return low.
- R6: Code 2 arms read mode and updates chip enable without any flash bus cycle; codes 0, 1 and 3 disarm read mode.
- R7: A host read of the data port while armed runs one read cycle (SETUP_CYC high, PULSE_CYC low, HOLD_CYC high on RE#, WE# high, bus not driven), samples the flash byte on the last low cycle of RE#, and returns it in bits 23:16 with every other bit zero.
- R8: A host read of the data port while not armed returns zero in the cycle after acceptance and runs no flash cycle.
- R9: A host read of the control port returns bit 15 set when the ready/busy input is low (busy) and clear when it is high, with all other bits zero, and runs no flash cycle.
- R10: CE# follows the inverse of the last accepted chip-enable bit from a control write with code 0 to 3, and holds that level across all later cycles and accesses.
- R11: hostReady drops in the cycle after a cycle-starting access is accepted and stays low for exactly SETUP_CYC+PULSE_CYC+HOLD_CYC cycles; a hostSel pulse while hostReady is low is ignored.
- R12: Control writes with codes 4 to 7, and any host write to the data port, are ignored: no flash cycle, and chip enable and read mode keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access request, taken when hostReady is high |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 1 | 0 = control/status port, 1 = data port |
| hostWdata | input | 32 | Host write word |
| hostRdata | output | 32 | Host read word |
| hostReady | output | 1 | High when a new access can be accepted |
| flashRbN | input | 1 | Flash ready/busy, low = busy |
| flashDin | input | 8 | Byte from the flash data bus |
| flashDout | output | 8 | Byte to the flash data bus |
| flashDoe | output | 1 | Drive enable for flashDout (low = tri-stated) |
| flashCeN | output | 1 | Chip enable, active low |
| flashCle | output | 1 | Command latch enable |
| flashAle | output | 1 | Address latch enable |
| flashWeN | output | 1 | Write strobe, active low |
| flashReN | output | 1 | Read strobe, active low |

## Verification
The bench builds the bridge with a setup of 2, a low pulse of 3 and a hold of 1, rather than the defaults. A two-cycle setup makes the phase counter wrap inside a phase, and the minimum hold covers the shortest phase. A three-cycle low pulse lets the bench drive a decoy byte on the earlier RE# low cycles, so sampling on any cycle other than the last one returns the wrong value.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  localparam int CE_BIT   = 31;
  localparam int OP_LSB   = 28;
  localparam int BYTE_LSB = 16;
  localparam int BUSY_BIT = 15;

  localparam logic [2:0] OP_CMD   = 3'd0;
  localparam logic [2:0] OP_ADDR  = 3'd1;
  localparam logic [2:0] OP_READ  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchCtl;
    logic armRead;
    logic disarmRead;
    logic loadStatus;
    logic loadZero;
    logic sample;
    logic driveBus;
    logic cleOn;
    logic aleOn;
    logic weLow;
    logic reLow;
  } strobe_t;

endpackage

// File: rtl/nbb_ctrl.sv
module nbb_ctrl
  import nbb_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostAddr,
  input  logic [2:0] opCode,
  input  logic       readMode,
  output strobe_t    stb,
  output logic       hostReady
);

  localparam int MAX_SP = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_C  = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             isRead;
  logic             cleKind;
  logic             aleKind;

  logic accept, ctlWrite, startWrite, startRead, phaseDone, busPhase;

  assign hostReady = (phase == PH_IDLE);
  assign accept    = hostSel && hostReady;
  assign ctlWrite  = accept && hostWr && !hostAddr;
  assign busPhase  = (phase != PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_SETUP: phaseDone = (cnt == SETUP_LAST);
      PH_PULSE: phaseDone = (cnt == PULSE_LAST);
      PH_HOLD:  phaseDone = (cnt == HOLD_LAST);
      default:  phaseDone = 1'b0;
    endcase
  end

  always_comb begin
    stb            = '0;
    stb.latchCtl   = ctlWrite && !opCode[2];
    stb.armRead    = ctlWrite && (opCode == OP_READ);
    stb.disarmRead = ctlWrite && !opCode[2] && (opCode != OP_READ);
    stb.loadStatus = accept && !hostWr && !hostAddr;
    stb.loadZero   = accept && !hostWr && hostAddr && !readMode;
    stb.driveBus   = busPhase && !isRead;
    stb.cleOn      = busPhase && cleKind;
    stb.aleOn      = busPhase && aleKind;
    stb.weLow      = (phase == PH_PULSE) && !isRead;
    stb.reLow      = (phase == PH_PULSE) && isRead;
    stb.sample     = (phase == PH_PULSE) && isRead && (cnt == PULSE_LAST);
  end

  assign startWrite = stb.disarmRead;
  assign startRead  = accept && !hostWr && hostAddr && readMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      isRead  <= 1'b0;
      cleKind <= 1'b0;
      aleKind <= 1'b0;
    end else if (phase == PH_IDLE) begin
      cnt <= '0;
      if (startWrite || startRead) begin
        phase   <= PH_SETUP;
        isRead  <= startRead;
        cleKind <= startWrite && (opCode == OP_CMD);
        aleKind <= startWrite && (opCode == OP_ADDR);
      end
    end else if (phaseDone) begin
      cnt <= '0;
      unique case (phase)
        PH_SETUP: phase <= PH_PULSE;
        PH_PULSE: phase <= PH_HOLD;
        default: begin
          phase   <= PH_IDLE;
          cleKind <= 1'b0;
          aleKind <= 1'b0;
        end
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/nbb_dpath.sv
module nbb_dpath
  import nbb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic        ceIn,
  input  logic [7:0]  byteIn,
  input  logic        flashRbN,
  input  logic [7:0]  flashDin,
  output logic [31:0] hostRdata,
  output logic        readMode,
  output logic [7:0]  flashDout,
  output logic        flashDoe,
  output logic        flashCeN,
  output logic        flashCle,
  output logic        flashAle,
  output logic        flashWeN,
  output logic        flashReN
);

  logic       ceOn;
  logic [7:0] outByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceOn     <= 1'b0;
      outByte  <= '0;
      readMode <= 1'b0;
    end else begin
      if (stb.latchCtl) begin
        ceOn    <= ceIn;
        outByte <= byteIn;
      end
      if (stb.armRead)         readMode <= 1'b1;
      else if (stb.disarmRead) readMode <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (stb.loadStatus) begin
      hostRdata           <= '0;
      hostRdata[BUSY_BIT] <= ~flashRbN;
    end else if (stb.loadZero) begin
      hostRdata <= '0;
    end else if (stb.sample) begin
      hostRdata               <= '0;
      hostRdata[BYTE_LSB +: 8] <= flashDin;
    end
  end

  assign flashCeN  = ~ceOn;
  assign flashCle  = stb.cleOn;
  assign flashAle  = stb.aleOn;
  assign flashWeN  = ~stb.weLow;
  assign flashReN  = ~stb.reLow;
  assign flashDout = outByte;
  assign flashDoe  = stb.driveBus;

endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic        hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostReady,
  input  logic        flashRbN,
  input  logic [7:0]  flashDin,
  output logic [7:0]  flashDout,
  output logic        flashDoe,
  output logic        flashCeN,
  output logic        flashCle,
  output logic        flashAle,
  output logic        flashWeN,
  output logic        flashReN
);

  strobe_t stb;
  logic    readMode;
  logic    unusedBits;

  assign unusedBits = &{1'b0, hostWdata[27:24], hostWdata[15:0]};

  nbb_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostSel  (hostSel),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .opCode   (hostWdata[OP_LSB +: 3]),
    .readMode (readMode),
    .stb      (stb),
    .hostReady(hostReady)
  );

  nbb_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .ceIn     (hostWdata[CE_BIT]),
    .byteIn   (hostWdata[BYTE_LSB +: 8]),
    .flashRbN (flashRbN),
    .flashDin (flashDin),
    .hostRdata(hostRdata),
    .readMode (readMode),
    .flashDout(flashDout),
    .flashDoe (flashDoe),
    .flashCeN (flashCeN),
    .flashCle (flashCle),
    .flashAle (flashAle),
    .flashWeN (flashWeN),
    .flashReN (flashReN)
  );

endmodule

// File: rtl/nbb_checker.sv
module nbb_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hostSel,
  input logic       hostWr,
  input logic       hostAddr,
  input logic       hostReady,
  input logic [7:0] flashDout,
  input logic       flashDoe,
  input logic       flashCeN,
  input logic       flashCle,
  input logic       flashAle,
  input logic       flashWeN,
  input logic       flashReN
);

  // R5: write and read strobes never low together
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWeN && !flashReN));

  // R2: command and address latch never both high
  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(flashCle && flashAle));

  // R11: host is held off whenever a strobe is active
  p_wait_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN || !flashReN) |-> !hostReady);

  // R7: bus released during a read pulse
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    !flashReN |-> !flashDoe);

  // R5: bus driven during a write pulse
  p_write_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> flashDoe);

  // R5: driven byte stays stable while the bus stays driven
  p_dout_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flashDoe && $past(flashDoe)) |-> $stable(flashDout));

  // R10: chip enable only moves after an accepted control write
  p_ce_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(hostSel && hostReady && hostWr && !hostAddr) |=> $stable(flashCeN));

endmodule

bind nand_bus_bridge nbb_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostSel  (hostSel),
  .hostWr   (hostWr),
  .hostAddr (hostAddr),
  .hostReady(hostReady),
  .flashDout(flashDout),
  .flashDoe (flashDoe),
  .flashCeN (flashCeN),
  .flashCle (flashCle),
  .flashAle (flashAle),
  .flashWeN (flashWeN),
  .flashReN (flashReN)
);

// File: tb/nand_bus_bridge_test.sv
module nand_bus_bridge_test;

  localparam int S = 2;
  localparam int P = 3;
  localparam int H = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostAddr = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostReady;
  logic        flashRbN = 1'b1;
  logic [7:0]  flashDin = '0;
  logic [7:0]  flashDout;
  logic        flashDoe, flashCeN, flashCle, flashAle, flashWeN, flashReN;

  int compared = 0;
  int mismatched = 0;
  bit ceM = 1'b0;
  bit rdM = 1'b0;

  always #10 clk = ~clk;

  nand_bus_bridge #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostReady(hostReady), .flashRbN(flashRbN), .flashDin(flashDin),
    .flashDout(flashDout), .flashDoe(flashDoe), .flashCeN(flashCeN),
    .flashCle(flashCle), .flashAle(flashAle), .flashWeN(flashWeN),
    .flashReN(flashReN)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlWord(input bit ce, input logic [2:0] op,
                                          input logic [7:0] b);
    return {ce, op, 4'h0, b, 16'h0};
  endfunction

  function automatic logic [31:0] rdWord(input logic [7:0] b);
    return {8'h0, b, 16'h0};
  endfunction

  task automatic issue(input bit wr, input bit addr, input logic [31:0] d);
    while (!hostReady) @(negedge clk);
    hostSel = 1'b1; hostWr = wr; hostAddr = addr; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0;
  endtask

  task automatic checkIdlePins(input string req);
    chk(flashCle == 0 && flashAle == 0 && flashWeN == 1 && flashReN == 1 &&
        flashDoe == 0, req, {27'h0, flashCle, flashAle, flashWeN, flashReN, flashDoe},
        32'h6);
  endtask

  // Walk the bus cycle one clock at a time, starting at index startIdx
  task automatic runCycle(input bit expCycle, input bit isRd, input bit eCle,
                          input bit eAle, input logic [7:0] b, input int startIdx,
                          input string req);
    int n = startIdx;
    int bad = 0;
    while (!hostReady && n < 100) begin
      bit inPulse = (n >= S) && (n < S + P);
      if (isRd) begin
        if (flashReN != !inPulse || flashWeN != 1 || flashDoe != 0 ||
            flashCle != 0 || flashAle != 0) bad++;
        flashDin = (n == S + P - 1) ? b : ~b;
      end else begin
        if (flashWeN != !inPulse || flashReN != 1 || flashDoe != 1 ||
            flashDout != b || flashCle != eCle || flashAle != eAle) bad++;
      end
      n++;
      @(negedge clk);
    end
    chk(n == (expCycle ? S + P + H : startIdx), {req, "/R11 wait length"}, n,
        expCycle ? S + P + H : startIdx);
    chk(bad == 0, {req, "/R5 strobe shape"}, bad, 0);
    checkIdlePins({req, "/R5 release"});
  endtask

  task automatic ctlWrite(input logic [2:0] op, input logic [7:0] b, input bit ce);
    string tag;
    bit cyc = (op == 0) || (op == 1) || (op == 3);
    tag = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 3) ? "R4" :
          (op == 2) ? "R6" : "R12";
    issue(1'b1, 1'b0, ctlWord(ce, op, b));
    if (!op[2]) ceM = ce;
    if (op == 2) rdM = 1'b1;
    else if (cyc) rdM = 1'b0;
    runCycle(cyc, 1'b0, op == 0, op == 1, b, 0, tag);
    chk(flashCeN == !ceM, {tag, "/R10 chip enable"}, flashCeN, !ceM);
  endtask

  task automatic dataRead(input logic [7:0] b);
    string tag = rdM ? "R7" : "R8";
    issue(1'b0, 1'b1, 32'h0);
    runCycle(rdM, 1'b1, 1'b0, 1'b0, b, 0, tag);
    chk(hostRdata == (rdM ? rdWord(b) : 32'h0), {tag, " read data"}, hostRdata,
        rdM ? rdWord(b) : 32'h0);
    chk(flashCeN == !ceM, {tag, "/R10 chip enable"}, flashCeN, !ceM);
  endtask

  task automatic statusRead(input bit busy);
    flashRbN = !busy;
    issue(1'b0, 1'b0, 32'hFFFF_FFFF);
    chk(hostReady == 1'b1, "R9 no wait", hostReady, 1);
    chk(hostRdata == (busy ? 32'h0000_8000 : 32'h0), "R9 status", hostRdata,
        busy ? 32'h0000_8000 : 32'h0);
    flashRbN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_2468));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(flashCeN == 1'b1, "R1 CE# high", flashCeN, 1);
    chk(hostReady == 1'b1, "R1 ready", hostReady, 1);
    checkIdlePins("R1 idle pins");
    dataRead(8'h5A); // R1 read mode off, R8

    // Directed
    ctlWrite(3'd0, 8'h90, 1'b1);   // R2 command latch
    ctlWrite(3'd1, 8'h00, 1'b1);   // R3 address latch
    ctlWrite(3'd3, 8'hC3, 1'b1);   // R4 data write
    ctlWrite(3'd2, 8'h00, 1'b1);   // R6 arm
    dataRead(8'hA5);               // R7
    dataRead(8'h3C);               // R7 sticky
    ctlWrite(3'd6, 8'h11, 1'b0);   // R12 ignored, CE stays
    dataRead(8'h81);               // R12 read mode kept
    issue(1'b1, 1'b1, ctlWord(1'b0, 3'd0, 8'h77)); // R12 data port write
    runCycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 0, "R12 data write");
    chk(flashCeN == 1'b0, "R12 CE kept", flashCeN, 0);
    dataRead(8'h42);               // still armed
    ctlWrite(3'd3, 8'hEE, 1'b1);   // R6 disarm
    dataRead(8'h99);               // R8
    statusRead(1'b1);              // R9
    statusRead(1'b0);
    ctlWrite(3'd1, 8'h12, 1'b0);   // R10 CE off

    // R11: hostSel pulse while the cycle runs is ignored
    issue(1'b1, 1'b0, ctlWord(1'b1, 3'd0, 8'hB4));
    ceM = 1'b1;
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = 1'b0;
    hostWdata = ctlWord(1'b0, 3'd1, 8'h0F);
    runCycle(1'b1, 1'b0, 1'b1, 1'b0, 8'hB4, 0, "R11 busy ignore");
    hostSel = 1'b0;
    chk(flashCeN == 1'b0, "R11 CE unchanged", flashCeN, 0);
    @(negedge clk);
    checkIdlePins("R11 no extra cycle");

    // Random mix
    for (int i = 0; i < 80; i++) begin
      int r = $urandom % 10;
      if (r < 6) ctlWrite(3'($urandom), 8'($urandom), 1'($urandom));
      else if (r < 8) dataRead(8'($urandom));
      else statusRead(1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule